// File: doc/BRIEF.md
# Capture and Reload Down-Counter Timer

A 16-bit timer that counts down from a software-loaded reload value. It has a capture register and two external event inputs, `cp1In` and `cp2In`. Each event input passes through a two-flop synchroniser and a rising-edge detector. Every detected event sets that channel's flag, or its error bit when the flag is already pending. Software clears these bits by writing ones to them.

The `restartSel` input picks one of two restart schemes. In edge-restart mode (`2'b10`) a CP2 event first copies the counter into the capture register and then reloads the counter. In that mode the counter stays idle until the first such event. In software-restart mode (any other value) a rising `run` reloads the counter and starts it, and CP2 only strobes captures. A capture is blocked while the CP2 flag or CP2 error bit is pending; the reload still happens. When the counter reaches zero it wraps to the reload value and pulses `underflow`. CP1 events only record status.

Top module: `capreload_timer`

## Requirements
- R1: After reset the counter, the capture register, the status bits and `underflow` are all zero.
- R2: While started and `run` is high, each cycle with `tick` high lowers the counter by one. With `tick` low, or with `run` low, the counter holds its value.
- R3: In software-restart mode (`restartSel` not `2'b10`), the cycle in which `run` is first seen high loads the counter from the reload register and starts counting. A CP2 event in this mode captures the counter but never changes it.
- R4: In edge-restart mode (`restartSel == 2'b10`), a CP2 event while `run` is high captures the old counter value and then reloads the counter and starts it. The first event after reset therefore captures 0000h. Before that first event, ticks do not move the counter.
- R5: A CP2 event captures only when status bits 2 and 3 are both clear. Otherwise the capture register is unchanged, and in edge-restart mode the reload still occurs.
- R6: A CP2 event sets status bit 2 (CP2 flag) when that bit is clear, and otherwise sets status bit 3 (CP2 error).
- R7: A CP1 event sets status bit 0 (CP1 flag) when that bit is clear, and otherwise sets bit 1 (CP1 error). It changes neither the counter nor the capture register.
- R8: Writing status (address 2) clears each bit written as 1. An event arriving in the same cycle as a clear leaves its bit set.
- R9: A tick while the started counter is at 0000h reloads the counter from the reload register. `underflow` is then high for exactly the one following cycle.
- R10: An event acts on the third rising clock edge after its input rises, and only a rising input edge counts. The register addresses are: 0 = reload (read/write), 1 = capture (read), 2 = status (read, write 1 to clear), 3 = counter (read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run/restart control |
| tick | input | 1 | Count enable for the current cycle |
| restartSel | input | 2 | Restart scheme select |
| cp1In | input | 1 | Event input 1, asynchronous |
| cp2In | input | 1 | Event input 2, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Register read data, combinational |
| underflow | output | 1 | One-cycle pulse after a wrap reload |

## Verification
The hardest case to reach from the ports is a status clear and a new event landing in the same clock edge. The bench raises an event input and counts negative edges through the synchroniser. It then places the write-1-to-clear exactly in the cycle in which the edge detector fires, and it checks the status both just before and just after that edge. The bench also reaches the blocked-capture case by leaving the CP2 flag pending and firing a second CP2 event. It then checks that the counter is reloaded while the capture register keeps its old value.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int CNT_W = 16;
  localparam logic [1:0] ADDR_RELOAD = 2'd0;
  localparam logic [1:0] ADDR_CAPT   = 2'd1;
  localparam logic [1:0] ADDR_STAT   = 2'd2;
  localparam logic [1:0] ADDR_CNT    = 2'd3;
  localparam logic [1:0] SEL_EDGE    = 2'b10;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic capture;
    logic wrap;
  } crtStrobe_t;
endpackage

// File: rtl/crt_ctrl.sv
module crt_ctrl
  import crt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] restartSel,
  input  logic       cp1In,
  input  logic       cp2In,
  input  logic       cntZero,
  input  logic       statClr,
  input  logic [3:0] clrMask,
  output crtStrobe_t strobe,
  output logic [3:0] status
);
  localparam int NCH = 2;

  logic [NCH-1:0] rawIn;
  logic [NCH-1:0] evt;
  assign rawIn = {cp2In, cp1In};

  // per-channel synchroniser and rising-edge detector
  for (genvar ch = 0; ch < NCH; ch++) begin : g_sync
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   lastQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
        lastQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn[ch]};
        lastQ <= syncQ[SYNC_STAGES-1];
      end
    end
    assign evt[ch] = syncQ[SYNC_STAGES-1] & ~lastQ;
  end

  logic cp1Ev, cp2Ev;
  assign cp1Ev = evt[0];
  assign cp2Ev = evt[1];

  logic runQ, active, swMode, loadEvt;
  assign swMode = (restartSel != SEL_EDGE);
  assign loadEvt = swMode ? (run & ~runQ) : (run & cp2Ev);

  always_comb begin
    strobe.wrap    = run & active & tick & cntZero & ~loadEvt;
    strobe.loadCnt = loadEvt | strobe.wrap;
    strobe.decCnt  = run & active & tick & ~cntZero & ~loadEvt;
    strobe.capture = cp2Ev & ~status[2] & ~status[3] & (swMode | run);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      active <= 1'b0;
    end else begin
      runQ <= run;
      if (!run)               active <= 1'b0;
      else if (strobe.loadCnt) active <= 1'b1;
    end
  end

  // flag/error per channel; new event wins over a clear
  for (genvar ch = 0; ch < NCH; ch++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        status[2*ch]   <= 1'b0;
        status[2*ch+1] <= 1'b0;
      end else begin
        if (evt[ch])                       status[2*ch] <= 1'b1;
        else if (statClr && clrMask[2*ch]) status[2*ch] <= 1'b0;
        if (evt[ch] && status[2*ch])         status[2*ch+1] <= 1'b1;
        else if (statClr && clrMask[2*ch+1]) status[2*ch+1] <= 1'b0;
      end
    end
  end

  assert_cp2_err_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cp2Ev && status[2]) |=> status[3]);
  assert_cp1_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    cp1Ev |=> status[0]);
  assert_no_dec_on_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.decCnt && strobe.loadCnt));
endmodule

// File: rtl/crt_datapath.sv
module crt_datapath
  import crt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  crtStrobe_t   strobe,
  input  logic         wrReload,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] cnt,
  output logic [W-1:0] capReg,
  output logic [W-1:0] reloadReg,
  output logic         cntZero,
  output logic         underflow
);
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      capReg    <= '0;
      reloadReg <= '0;
      underflow <= 1'b0;
    end else begin
      if (wrReload)           reloadReg <= wrData;
      if (strobe.capture)     capReg <= cnt;   // old value: capture precedes reload
      if (strobe.loadCnt)     cnt <= reloadReg;
      else if (strobe.decCnt) cnt <= cnt - 1'b1;
      underflow <= strobe.wrap;
    end
  end

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> cnt == $past(reloadReg));
  assert_capture_old_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> capReg == $past(cnt));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadCnt && !strobe.decCnt) |=> $stable(cnt));
  assert_dec_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCnt |=> cnt == $past(cnt) - 1'b1);
  assert_uflow_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> !underflow);
endmodule

// File: rtl/capreload_timer.sv
module capreload_timer
  import crt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             tick,
  input  logic [1:0]       restartSel,
  input  logic             cp1In,
  input  logic             cp2In,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             underflow
);
  crtStrobe_t       strobe;
  logic [3:0]       status;
  logic             cntZero;
  logic [CNT_W-1:0] cnt, capReg, reloadReg;

  crt_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .tick(tick), .restartSel(restartSel),
    .cp1In(cp1In), .cp2In(cp2In), .cntZero(cntZero),
    .statClr(wrEn && wrAddr == ADDR_STAT), .clrMask(wrData[3:0]),
    .strobe(strobe), .status(status)
  );

  crt_datapath #(.W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrReload(wrEn && wrAddr == ADDR_RELOAD), .wrData(wrData),
    .cnt(cnt), .capReg(capReg), .reloadReg(reloadReg),
    .cntZero(cntZero), .underflow(underflow)
  );

  always_comb begin
    unique case (rdAddr)
      ADDR_RELOAD: rdData = reloadReg;
      ADDR_CAPT:   rdData = capReg;
      ADDR_STAT:   rdData = {{(CNT_W-4){1'b0}}, status};
      default:     rdData = cnt;
    endcase
  end
endmodule

// File: tb/test_capreload_timer.sv
`timescale 1ns/1ps
module test_capreload_timer;
  logic clk = 1'b0, rstN = 1'b0, run = 1'b0, tick = 1'b0;
  logic [1:0] restartSel = 2'b00;
  logic cp1In = 1'b0, cp2In = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0, rdAddr = 2'd0;
  logic [15:0] wrData = '0, rdData;
  logic underflow;
  int total = 0, bad = 0;
  bit  finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  capreload_timer i_capreload_timer (
    .clk(clk), .rstN(rstN), .run(run), .tick(tick), .restartSel(restartSel),
    .cp1In(cp1In), .cp2In(cp2In), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .underflow(underflow)
  );

  // {reload, ticks} walked in software-restart mode
  localparam logic [31:0] VEC [4] = '{
    {16'd100, 16'd5}, {16'hFFFF, 16'd3}, {16'h8000, 16'd17}, {16'd2, 16'd2}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, string req, logic [15:0] exp);
    rdAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse(bit useCp2);
    if (useCp2) cp2In = 1'b1; else cp1In = 1'b1;
    repeat (4) @(negedge clk);
    cp1In = 1'b0; cp2In = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 underflow", {15'd0, underflow}, 16'd0);
    rd(2'd3, "R1 counter", 16'd0);
    rd(2'd1, "R1 capture", 16'd0);
    rd(2'd2, "R1 status", 16'd0);
    rstN = 1'b1;
    @(negedge clk);

    // edge-restart mode, first event captures zero (R4)
    restartSel = 2'b10;
    wr(2'd0, 16'd50);
    run = 1'b1;
    @(negedge clk);
    ticks(3);
    rd(2'd3, "R4 idle before first event", 16'd0);
    pulse(1);
    rd(2'd1, "R4 first capture is zero", 16'd0);
    rd(2'd3, "R4 reload on event", 16'd50);
    rd(2'd2, "R6 cp2 flag set", 16'h4);
    ticks(10);
    rd(2'd3, "R2 ten ticks", 16'd40);
    pulse(1);
    rd(2'd1, "R5 capture blocked", 16'd0);
    rd(2'd3, "R5 reload still done", 16'd50);
    rd(2'd2, "R6 cp2 error set", 16'hC);

    wr(2'd2, 16'hC);
    rd(2'd2, "R8 clear", 16'h0);
    ticks(5);
    pulse(1);
    rd(2'd1, "R4 capture old count", 16'd45);
    rd(2'd3, "R4 reload after capture", 16'd50);

    // CP1 has no counter/capture effect (R7)
    ticks(2);
    pulse(0);
    rd(2'd3, "R7 counter untouched", 16'd48);
    rd(2'd1, "R7 capture untouched", 16'd45);
    rd(2'd2, "R7 cp1 flag", 16'h5);
    pulse(0);
    rd(2'd2, "R7 cp1 error", 16'h7);

    // wrap and underflow pulse (R9)
    wr(2'd2, 16'hF);
    wr(2'd0, 16'd3);
    pulse(1);
    rd(2'd1, "R4 capture 48", 16'd48);
    rd(2'd3, "R9 reload 3", 16'd3);
    ticks(3);
    rd(2'd3, "R9 reached zero", 16'd0);
    check("R9 no early pulse", {15'd0, underflow}, 16'd0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R9 pulse high", {15'd0, underflow}, 16'd1);
    rd(2'd3, "R9 wrapped to reload", 16'd3);
    @(negedge clk);
    check("R9 pulse one cycle", {15'd0, underflow}, 16'd0);

    // run low: hold, and CP2 does not restart or capture (R2)
    run = 1'b0;
    @(negedge clk);
    ticks(5);
    rd(2'd3, "R2 hold with run low", 16'd3);
    wr(2'd2, 16'hF);
    pulse(1);
    rd(2'd3, "R2 no reload with run low", 16'd3);
    rd(2'd1, "R2 no capture with run low", 16'd48);

    // same-cycle clear and event, plus latency (R8, R10)
    wr(2'd2, 16'hF);
    cp1In = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(2'd2, "R10 not yet after two edges", 16'h0);
    wrEn = 1'b1; wrAddr = 2'd2; wrData = 16'h1;
    @(negedge clk);
    wrEn = 1'b0;
    rd(2'd2, "R8 event wins over clear", 16'h1);
    repeat (4) @(negedge clk);
    rd(2'd2, "R10 held level is one event", 16'h1);
    cp1In = 1'b0;
    repeat (3) @(negedge clk);

    // software-restart mode: CP2 captures only (R3)
    restartSel = 2'b00;
    wr(2'd2, 16'hF);
    run = 1'b1;
    @(negedge clk);
    rd(2'd3, "R3 load on run rise", 16'd3);
    ticks(1);
    pulse(1);
    rd(2'd1, "R3 strobe capture", 16'd2);
    rd(2'd3, "R3 no restart", 16'd2);
    run = 1'b0;
    @(negedge clk);

    // vector table (R2, R3)
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, VEC[i][31:16]);
      run = 1'b1;
      @(negedge clk);
      ticks(int'(VEC[i][15:0]));
      rd(2'd3, "R3 table count", VEC[i][31:16] - VEC[i][15:0]);
      run = 1'b0;
      @(negedge clk);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule